// File: doc/BRIEF.md
# Programmable Target/Overflow Timer Channel

A 16-bit timer channel that a processor drives through three small registers: the live count, a mode word and a target value. The count moves up by one on every cycle where the selected clock enable is active. Each step can hit the target value, or wrap from 0xFFFF to 0x0000. Either event can restart the count, set sticky status bits in the mode word, and raise one interrupt pulse. The interrupt fires either once per mode write or on every event.

A parameter picks one of three channel flavours. The pixel flavour can count an external one-cycle pixel tick. The line flavour can count an external one-cycle line tick. The divide flavour can count every eighth system clock, and it has a bit that stops counting. Register select codes: 0 selects the count, 1 the mode word, 2 the target, 3 nothing (reads zero, writes ignored). The one-shot behaviour is a two-state machine. In state ARMED, a qualifying event pulses the interrupt. Without the repeat bit, the transition ARMED→SPENT follows that pulse. A mode write moves SPENT→ARMED. With the repeat bit set, the machine stays in ARMED.

Top module: `rcnt_channel`

## Requirements
- R1: After reset the count, mode word and target read zero and irq is low; a write with select 0 loads the count with wdata.
- R2: Each active clock enable adds one to the count. With mode bit 3 set, the step that would make the count equal the target sets it to 0 instead, and that step is a target event.
- R3: With mode bit 3 clear, the count runs on past the target (the step that reaches it is still a target event) and wraps from 0xFFFF to 0x0000; the wrapping step is an overflow event.
- R4: A target event with mode bit 4 set, or an overflow event with mode bit 5 set, drives irq high for exactly the one cycle after the event's clock edge.
- R5: With mode bit 6 clear, only the first qualifying event after a mode write pulses irq; with bit 6 set, every qualifying event does.
- R6: Mode bit 11 (target reached) and bit 12 (overflow) are set by their events and stay set until a mode-register read (rd_en with select 1) clears them at that edge; an event in the same cycle wins over the clear. Bit 10 is set by either event and is not cleared by reads.
- R7: A mode write (select 1) stores wdata bits 0 to 9, stores zero in bits 10 to 15, sets the count to 0 and re-arms the one-shot interrupt.
- R8: A target write (select 2) replaces the target and leaves the count unchanged.
- R9: Pixel flavour: mode bit 8 set counts px_tick pulses; clear counts every system clock.
- R10: Line flavour: mode bit 8 set counts ln_tick pulses; clear counts every system clock.
- R11: Divide flavour: mode bit 9 set advances the count on every eighth clock. A mode write restarts the prescaler, so the first step comes on the eighth edge after that write.
- R12: Divide flavour: mode bit 0 set holds the count; count writes still load it.
- R13: In a cycle with a register write (select 0 to 2), the clock enable is ignored: no step and no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_tick | input | 1 | One-cycle pixel clock enable |
| ln_tick | input | 1 | One-cycle line clock enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags on a mode read) |
| addr | input | 2 | Register select: 0 count, 1 mode, 2 target, 3 none |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register, combinational |
| irq | output | 1 | Interrupt request pulse |

## Verification
The assertions check several rules on every cycle. Count, mode and target writes have their stated effect on the count. Bits 13 to 15 of the mode word read zero. An irq pulse always comes with its status flags set. A one-shot pulse is never followed directly by another. Writes suppress events, a mode read clears the flags when no event is present, and the stop bit freezes the count. The benches' scenarios show the sequences over many cycles. These are the target period under reset-on-target, wrap timing, the number of one-shot versus repeating pulses, the prescaler phase after a mode write, and the external tick sources. A seeded random sweep compares these against a step-by-step model of the requirements.

// File: rtl/rcnt_pkg.sv
package rcnt_pkg;

    typedef enum logic [1:0] {
        FLV_PIXEL = 2'd0,
        FLV_LINE  = 2'd1,
        FLV_DIV8  = 2'd2
    } flavour_e;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_MODE   = 2'd1,
        SEL_TARGET = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        IRQ_ARMED = 1'b0,
        IRQ_SPENT = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic tgt;
        logic ovf;
    } cnt_ev_t;

    // mode word bit positions
    localparam int B_STOP    = 0;
    localparam int B_RST_TGT = 3;
    localparam int B_IRQ_TGT = 4;
    localparam int B_IRQ_OVF = 5;
    localparam int B_REPEAT  = 6;
    localparam int B_SRC     = 8;
    localparam int B_DIV     = 9;
    localparam int B_EVENT   = 10;
    localparam int B_HIT_TGT = 11;
    localparam int B_HIT_OVF = 12;

    // highest bit a mode write stores
    localparam int WR_TOP    = 9;

endpackage

// File: rtl/rcnt_tick_sel.sv
module rcnt_tick_sel
    import rcnt_pkg::*;
#(
    parameter flavour_e FLAVOUR = FLV_PIXEL,
    parameter int       PRE_W   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic src_sel,
    input  logic div_sel,
    input  logic stop,
    input  logic px_tick,
    input  logic ln_tick,
    output logic tick
);

    generate
        if (FLAVOUR == FLV_DIV8) begin : g_div
            logic [PRE_W-1:0] pre_q;
            logic             pre_full;
            logic             unused_in;

            assign pre_full  = (pre_q == {PRE_W{1'b1}});
            assign unused_in = ^{src_sel, px_tick, ln_tick};

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       pre_q <= '0;
                else if (mode_wr) pre_q <= '0;
                else              pre_q <= pre_q + 1'b1;
            end

            assign tick = !stop && (div_sel ? pre_full : 1'b1);
        end else if (FLAVOUR == FLV_LINE) begin : g_line
            logic unused_in;
            assign unused_in = ^{clk, rst_n, mode_wr, div_sel, stop, px_tick};
            assign tick      = src_sel ? ln_tick : 1'b1;
        end else begin : g_pixel
            logic unused_in;
            assign unused_in = ^{clk, rst_n, mode_wr, div_sel, stop, ln_tick};
            assign tick      = src_sel ? px_tick : 1'b1;
        end
    endgenerate

endmodule

// File: rtl/rcnt_core.sv
module rcnt_core
    import rcnt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_count,
    input  logic              wr_mode,
    input  logic              wr_target,
    input  logic              rd_mode,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] target_q,
    output cnt_ev_t           ev
);

    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << (WR_TOP + 1)) - 1);

    logic              any_wr;
    logic              step;
    logic [DATA_W:0]   nxt;
    logic [DATA_W-1:0] count_nx;
    logic [DATA_W-1:0] mode_nx;

    assign any_wr = wr_count || wr_mode || wr_target;
    assign step   = tick && !any_wr;
    assign nxt    = {1'b0, count_q} + (DATA_W + 1)'(1);

    assign ev.tgt = step && (nxt[DATA_W-1:0] == target_q);
    assign ev.ovf = step && nxt[DATA_W];

    always_comb begin
        count_nx = count_q;
        if (wr_count)                       count_nx = wdata;
        else if (wr_mode)                   count_nx = '0;
        else if (ev.tgt && mode_q[B_RST_TGT]) count_nx = '0;
        else if (step)                      count_nx = nxt[DATA_W-1:0];
    end

    always_comb begin
        mode_nx = mode_q;
        if (wr_mode) begin
            mode_nx = wdata & KEEP_MASK;
        end else begin
            if (rd_mode) begin
                mode_nx[B_HIT_TGT] = 1'b0;
                mode_nx[B_HIT_OVF] = 1'b0;
            end
            if (ev.tgt) begin
                mode_nx[B_HIT_TGT] = 1'b1;
                mode_nx[B_EVENT]   = 1'b1;
            end
            if (ev.ovf) begin
                mode_nx[B_HIT_OVF] = 1'b1;
                mode_nx[B_EVENT]   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            mode_q   <= '0;
            target_q <= '0;
        end else begin
            count_q <= count_nx;
            mode_q  <= mode_nx;
            if (wr_target) target_q <= wdata;
        end
    end

endmodule

// File: rtl/rcnt_irq.sv
module rcnt_irq
    import rcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rearm,
    input  logic req,
    input  logic rpt_en,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_nx;
    logic       fire;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            IRQ_ARMED: begin
                if (rearm)                state_nx = IRQ_ARMED;
                else if (req && !rpt_en)  state_nx = IRQ_SPENT;
            end
            IRQ_SPENT: begin
                if (rearm)                state_nx = IRQ_ARMED;
            end
            default:                      state_nx = IRQ_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_ARMED;
        else        state_q <= state_nx;
    end

    assign fire = !rearm && req && ((state_q == IRQ_ARMED) || rpt_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire;
    end

endmodule

// File: rtl/rcnt_channel.sv
module rcnt_channel
    import rcnt_pkg::*;
#(
    parameter flavour_e FLAVOUR = FLV_PIXEL,
    parameter int       DATA_W  = 16,
    parameter int       PRE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              px_tick,
    input  logic              ln_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic              wr_count;
    logic              wr_mode;
    logic              wr_target;
    logic              rd_mode;
    logic              tick;
    logic              irq_req;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] target_q;
    cnt_ev_t           ev;

    assign wr_count  = wr_en && (addr == SEL_COUNT);
    assign wr_mode   = wr_en && (addr == SEL_MODE);
    assign wr_target = wr_en && (addr == SEL_TARGET);
    assign rd_mode   = rd_en && (addr == SEL_MODE);

    rcnt_tick_sel #(
        .FLAVOUR (FLAVOUR),
        .PRE_W   (PRE_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (wr_mode),
        .src_sel (mode_q[B_SRC]),
        .div_sel (mode_q[B_DIV]),
        .stop    (mode_q[B_STOP]),
        .px_tick (px_tick),
        .ln_tick (ln_tick),
        .tick    (tick)
    );

    rcnt_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_count  (wr_count),
        .wr_mode   (wr_mode),
        .wr_target (wr_target),
        .rd_mode   (rd_mode),
        .wdata     (wdata),
        .tick      (tick),
        .count_q   (count_q),
        .mode_q    (mode_q),
        .target_q  (target_q),
        .ev        (ev)
    );

    assign irq_req = (ev.tgt && mode_q[B_IRQ_TGT]) || (ev.ovf && mode_q[B_IRQ_OVF]);

    rcnt_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .rearm  (wr_mode),
        .req    (irq_req),
        .rpt_en (mode_q[B_REPEAT]),
        .irq    (irq)
    );

    always_comb begin
        unique case (addr)
            SEL_COUNT:  rdata = count_q;
            SEL_MODE:   rdata = mode_q;
            SEL_TARGET: rdata = target_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/rcnt_channel_chk.sv
module rcnt_channel_chk
    import rcnt_pkg::*;
#(
    parameter flavour_e FLAVOUR = FLV_PIXEL,
    parameter int       DATA_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] mode_q,
    input logic              ev_tgt,
    input logic              ev_ovf
);

    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_COUNT) |=> (count_q == $past(wdata))); // R1

    AST_TARGET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_TARGET) |=> (count_q == $past(count_q))); // R8

    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_MODE) |=> (count_q == '0 && mode_q[15:10] == '0)); // R7

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == SEL_MODE) |-> (rdata[15:13] == 3'b000)); // R7

    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((mode_q[B_HIT_TGT] || mode_q[B_HIT_OVF]) && mode_q[B_EVENT])); // R4

    AST_ONESHOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !mode_q[B_REPEAT]) |=> !irq); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == SEL_MODE && !wr_en && !ev_tgt && !ev_ovf)
        |=> (mode_q[B_HIT_OVF:B_HIT_TGT] == 2'b00)); // R6

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[B_EVENT] && !(wr_en && addr == SEL_MODE)) |=> mode_q[B_EVENT]); // R6

    AST_WRITE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != SEL_NONE) |-> (!ev_tgt && !ev_ovf)); // R13

    generate
        if (FLAVOUR == FLV_DIV8) begin : g_stop_chk
            AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_q[B_STOP] && !wr_en) |=> $stable(count_q)); // R12
        end
    endgenerate

endmodule

bind rcnt_channel rcnt_channel_chk #(
    .FLAVOUR (FLAVOUR),
    .DATA_W  (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .count_q (count_q),
    .mode_q  (mode_q),
    .ev_tgt  (ev.tgt),
    .ev_ovf  (ev.ovf)
);

// File: tb/rcnt_channel_tb.sv
`timescale 1ns/1ps
module rcnt_channel_tb;
    import rcnt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        px_tick = 1'b0;
    logic        ln_tick = 1'b0;
    logic [2:0]  wr_en = '0;
    logic [2:0]  rd_en = '0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rd0, rd1, rd2;
    logic        irq0, irq1, irq2;

    int total = 0;
    int bad   = 0;
    int irq_cnt = 0;

    always #10 clk = ~clk;

    rcnt_channel #(.FLAVOUR(FLV_PIXEL)) u_dut (
        .clk(clk), .rst_n(rst_n), .px_tick(px_tick), .ln_tick(ln_tick),
        .wr_en(wr_en[0]), .rd_en(rd_en[0]), .addr(addr), .wdata(wdata),
        .rdata(rd0), .irq(irq0));

    rcnt_channel #(.FLAVOUR(FLV_LINE)) u_dut_line (
        .clk(clk), .rst_n(rst_n), .px_tick(px_tick), .ln_tick(ln_tick),
        .wr_en(wr_en[1]), .rd_en(rd_en[1]), .addr(addr), .wdata(wdata),
        .rdata(rd1), .irq(irq1));

    rcnt_channel #(.FLAVOUR(FLV_DIV8)) u_dut_div (
        .clk(clk), .rst_n(rst_n), .px_tick(px_tick), .ln_tick(ln_tick),
        .wr_en(wr_en[2]), .rd_en(rd_en[2]), .addr(addr), .wdata(wdata),
        .rdata(rd2), .irq(irq2));

    always @(negedge clk) if (irq0) irq_cnt++;

    // step-by-step model of the requirements (channel 0, system clock)
    int m_c;
    bit m_f10, m_f11, m_f12, m_armed;
    int m_pulses;

    task automatic model_step(input logic [15:0] md, input logic [15:0] tg);
        int nx;
        bit hit_t, hit_o, req;
        nx    = m_c + 1;
        hit_t = ((nx & 16'hFFFF) == int'(tg));
        hit_o = (nx == 65536);
        m_c   = (hit_t && md[3]) ? 0 : (nx & 16'hFFFF);
        if (hit_t) begin m_f11 = 1; m_f10 = 1; end
        if (hit_o) begin m_f12 = 1; m_f10 = 1; end
        req = (hit_t && md[4]) || (hit_o && md[5]);
        if (req && (m_armed || md[6])) begin
            m_pulses++;
            if (!md[6]) m_armed = 0;
        end
    endtask

    function automatic logic [15:0] rd_of(input int ch);
        return (ch == 0) ? rd0 : (ch == 1) ? rd1 : rd2;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // all tasks run at negedge+1
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic bus_wr(input int ch, input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en[ch] = 1'b1;
        @(negedge clk); #1;
        wr_en[ch] = 1'b0;
    endtask

    task automatic peek(input int ch, input logic [1:0] a, output logic [15:0] v);
        addr = a; #1;
        v = rd_of(ch);
    endtask

    task automatic run_trial(input logic [15:0] md, input logic [15:0] tg,
                             input logic [15:0] pre, input int n);
        logic [15:0] v;
        bus_wr(0, SEL_MODE, md);
        bus_wr(0, SEL_TARGET, tg);
        irq_cnt = 0;
        bus_wr(0, SEL_COUNT, pre);
        m_c = pre; m_f10 = 0; m_f11 = 0; m_f12 = 0; m_armed = 1; m_pulses = 0;
        for (int i = 0; i < n; i++) model_step(md, tg);
        idle(n);
        peek(0, SEL_COUNT, v);
        chk("R2/R3", "count", v, m_c);
        chk("R4/R5", "irq pulses", irq_cnt, m_pulses);
        peek(0, SEL_MODE, v);
        rd_en[0] = 1'b1;
        chk("R6", "flags", v[12:10], {m_f12, m_f11, m_f10});
        chk("R7", "stored mode", v[9:0], md[9:0]);
        m_f11 = 0; m_f12 = 0;
        model_step(md, tg);
        idle(1);
        rd_en[0] = 1'b0;
        peek(0, SEL_MODE, v);
        chk("R6", "flags after read", v[12:10], {m_f12, m_f11, m_f10});
    endtask

    initial begin
        #4_000_000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h1C0FFEE));
        #35 rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        for (int ch = 0; ch < 3; ch++) begin
            peek(ch, SEL_COUNT, v);  chk("R1", "reset count", v, 0);
            peek(ch, SEL_MODE, v);   chk("R1", "reset mode", v, 0);
            peek(ch, SEL_TARGET, v); chk("R1", "reset target", v, 0);
        end
        chk("R1", "reset irq", {irq2, irq1, irq0}, 0);

        // R13 write wins over tick; R1 load; R8 target write keeps count
        bus_wr(0, SEL_MODE, 16'h0000);
        bus_wr(0, SEL_COUNT, 16'd5);
        peek(0, SEL_COUNT, v); chk("R13", "count at write", v, 5);
        idle(1);
        peek(0, SEL_COUNT, v); chk("R2", "one step", v, 6);
        bus_wr(0, SEL_TARGET, 16'd100);
        peek(0, SEL_COUNT, v); chk("R8", "count kept", v, 6);
        peek(0, SEL_TARGET, v); chk("R8", "target", v, 100);

        // R9 pixel tick source
        bus_wr(0, SEL_MODE, 16'h0100);
        for (int i = 0; i < 5; i++) begin
            px_tick = 1'b1; idle(1); px_tick = 1'b0; idle(2);
        end
        peek(0, SEL_COUNT, v); chk("R9", "pixel ticks", v, 5);

        // R7 mode write masks, R10 line tick source
        bus_wr(1, SEL_MODE, 16'hFFFF);
        peek(1, SEL_MODE, v); chk("R7", "mode readback", v, 16'h03FF);
        peek(1, SEL_COUNT, v); chk("R7", "count cleared", v, 0);
        for (int i = 0; i < 3; i++) begin
            ln_tick = 1'b1; idle(1); ln_tick = 1'b0; idle(3);
        end
        peek(1, SEL_COUNT, v); chk("R10", "line ticks", v, 3);
        bus_wr(1, SEL_MODE, 16'h0000);
        idle(4);
        peek(1, SEL_COUNT, v); chk("R10", "system clock", v, 4);

        // R11 divide by eight and prescaler restart
        bus_wr(2, SEL_MODE, 16'h0200);
        idle(7);  peek(2, SEL_COUNT, v); chk("R11", "div 7 edges", v, 0);
        idle(1);  peek(2, SEL_COUNT, v); chk("R11", "div 8 edges", v, 1);
        idle(8);  peek(2, SEL_COUNT, v); chk("R11", "div 16 edges", v, 2);
        idle(3);
        bus_wr(2, SEL_MODE, 16'h0200);
        idle(7);  peek(2, SEL_COUNT, v); chk("R11", "restart 7", v, 0);
        idle(1);  peek(2, SEL_COUNT, v); chk("R11", "restart 8", v, 1);

        // R12 stop bit
        bus_wr(2, SEL_MODE, 16'h0001);
        idle(20); peek(2, SEL_COUNT, v); chk("R12", "stopped", v, 0);
        bus_wr(2, SEL_COUNT, 16'd9);
        idle(20); peek(2, SEL_COUNT, v); chk("R12", "stopped load", v, 9);

        // directed trials: R5 one-shot vs repeat, R3 wrap, R2 reset at target
        run_trial(16'h0018, 16'd3, 16'd0, 12);
        chk("R5", "one-shot count", irq_cnt, 1);
        run_trial(16'h0058, 16'd3, 16'd0, 12);
        chk("R5", "repeat count", irq_cnt, 4);
        run_trial(16'h0020, 16'd500, 16'hFFFE, 2);
        chk("R3", "wrap pulse", irq_cnt, 1);
        run_trial(16'h0070, 16'd0, 16'hFFF0, 40);

        // seeded random sweep
        for (int t = 0; t < 40; t++) begin
            logic [15:0] md, tg, pre;
            int n;
            md  = 16'($urandom_range(0, 15)) << 3;
            tg  = ($urandom_range(0, 9) == 0) ? 16'd0 : 16'($urandom_range(1, 200));
            pre = $urandom_range(0, 1) ? (16'hFF00 | 16'($urandom_range(0, 255)))
                                       : 16'($urandom_range(0, 150));
            n   = $urandom_range(1, 400);
            run_trial(md, tg, pre, n);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule